// File: doc/BRIEF.md
# Two-Lane Serial ADC Frame Deserializer

This block sits behind the input capture of a source-synchronous ADC link. The link carries one or two data lanes and a frame marker. The block works in one system clock domain. Each clock cycle, the capture stage hands it two samples of every lane and two samples of the frame marker: the bit taken on the rising edge of the forwarded data clock and the bit taken on the falling edge. The block finds word boundaries from transitions of the frame marker and reassembles the lane bits into parallel samples of `SAMPLE_W` bits. A one-cycle strobe marks each new sample.

The serialization width and the lane count are static configuration inputs. A sample may be sent as a word of `SAMPLE_W+2` bits, ending in two padding bits that are thrown away. It may be sent as a word of `SAMPLE_W` bits. It may also be sent truncated to `SAMPLE_W-2` bits, in which case the two missing low bits come back as zero. In the two-lane native-width mode the marker toggles once per sample, so both of its edges start words. A marker transition that arrives while a word is only partly collected sets a sticky error flag and restarts collection at that transition.

Top module: `adc_frame_deser`

## Requirements
- R1: Each cycle, bit 0 of `rise_data_i`/`fall_data_i` is lane 0 and bit 1 is lane 1. The rising-edge bit (`rise_data_i`, `frame_rise_i`) comes earlier in time than the falling-edge bit (`fall_data_i`, `frame_fall_i`), so a word may begin or end on either half of a cycle.
- R2: With `two_lane_i`=0, the whole serial word S arrives on lane 0, MSB first, and lane 1 is ignored. S is 16 bits for `ser_mode_i`=2'b00, 14 bits for 2'b01 and 12 bits for 2'b10. The value 2'b11 behaves as 2'b00.
- R3: With `two_lane_i`=1, each lane carries half of S, MSB first. Lane 1 carries the odd indices S[W-1], S[W-3], ... and lane 0 carries the even indices S[W-2], S[W-4], ...
- R4: In 16-bit mode, S = {sample, two padding bits}. `sample_o` = S[15:2], and the padding bits have no effect on it.
- R5: In 12-bit mode, S = sample[13:2], and `sample_o` = {S, 2'b00}.
- R6: A word starts at the bit where the sampled frame marker rises (0 then 1). In two-lane 14-bit mode, a fall (1 then 0) also starts a word, so one marker period carries two samples.
- R7: `sample_valid_o` is high for exactly one cycle per completed word. That cycle is the cycle after the clock edge that samples the word's last bit. `sample_o` holds its value until the next strobe.
- R8: No strobe appears before the first frame-marker transition after reset. The first marker sample after reset is compared with nothing.
- R9: A marker transition that starts a word while the previous word is incomplete sets `frame_err_o` from the next cycle until reset. The partial word produces no strobe, and collection restarts at that transition.
- R10: During and right after reset, `sample_valid_o`, `frame_err_o` and `sample_o` are all 0.
- R11: Once aligned, if a word completes and no marker transition follows, the next bits form the next word. A missing transition is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_lane_i | input | 1 | 0 = one lane, 1 = two lanes |
| ser_mode_i | input | 2 | Serialization width: 00 = 16, 01 = 14, 10 = 12, 11 = 16 |
| rise_data_i | input | 2 | Lane bits captured on the rising data-clock edge (bit n = lane n) |
| fall_data_i | input | 2 | Lane bits captured on the falling data-clock edge |
| frame_rise_i | input | 1 | Frame marker captured on the rising edge |
| frame_fall_i | input | 1 | Frame marker captured on the falling edge |
| sample_o | output | SAMPLE_W | Reassembled sample |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
A completed word appears on `sample_valid_o` and `sample_o` one cycle after the clock edge that samples its last bit. The error flag rises one cycle after the edge that samples the offending marker transition. For every cycle of a run, the bench works out from the generated half-bit stream which cycle each word ends in, and which cycle the first misplaced transition falls in. It drives each cycle's inputs at the falling clock edge and checks the registered outputs one falling edge later, so each result is compared exactly in the cycle it is due.

// File: rtl/adcdes_pkg.sv
package adcdes_pkg;
    typedef enum logic [1:0] {
        SER_PAD    = 2'b00,
        SER_NATIVE = 2'b01,
        SER_TRUNC  = 2'b10,
        SER_RSVD   = 2'b11
    } ser_mode_e;

    localparam int HALVES_PER_CLK = 2;
endpackage

// File: rtl/adcdes_cfg_decode.sv
module adcdes_cfg_decode
    import adcdes_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int CNT_W    = 5
) (
    input  logic             two_lane_i,
    input  logic [1:0]       ser_i,
    output logic [CNT_W-1:0] bpl_o,
    output logic             split_o
);
    localparam int W_PAD = SAMPLE_W + 2;
    localparam int W_NAT = SAMPLE_W;
    localparam int W_TRN = SAMPLE_W - 2;

    ser_mode_e ser;
    int        word_w;

    always_comb begin
        ser = ser_mode_e'(ser_i);
        case (ser)
            SER_NATIVE: word_w = W_NAT;
            SER_TRUNC:  word_w = W_TRN;
            default:    word_w = W_PAD;
        endcase
        // bits per lane for one sample
        bpl_o   = two_lane_i ? CNT_W'(word_w / 2) : CNT_W'(word_w);
        // two-lane native width: marker toggles once per sample
        split_o = two_lane_i && (ser == SER_NATIVE);
    end
endmodule

// File: rtl/adcdes_bit_step.sv
module adcdes_bit_step #(
    parameter int SH0_W = 16,
    parameter int SH1_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             prev_f_i,
    input  logic             prev_ok_i,
    input  logic             aligned_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [SH0_W-1:0] sh0_i,
    input  logic [SH1_W-1:0] sh1_i,
    input  logic             b0_i,
    input  logic             b1_i,
    input  logic             f_i,
    input  logic [CNT_W-1:0] bpl_i,
    input  logic             split_i,
    output logic             prev_f_o,
    output logic             prev_ok_o,
    output logic             aligned_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [SH0_W-1:0] sh0_o,
    output logic [SH1_W-1:0] sh1_o,
    output logic             done_o,
    output logic             err_o
);
    logic             frm_edge;
    logic [CNT_W-1:0] cnt_n;
    logic [SH0_W-1:0] sh0_shift;
    logic [SH1_W-1:0] sh1_shift;

    always_comb begin
        frm_edge  = prev_ok_i && ((!prev_f_i && f_i) || (split_i && prev_f_i && !f_i));
        sh0_shift = (sh0_i << 1) | SH0_W'(b0_i);
        sh1_shift = (sh1_i << 1) | SH1_W'(b1_i);
        cnt_n     = cnt_i;
        aligned_o = aligned_i;
        sh0_o     = sh0_i;
        sh1_o     = sh1_i;
        err_o     = 1'b0;
        done_o    = 1'b0;
        if (frm_edge) begin
            // a word boundary while bits are pending means lost alignment
            err_o     = aligned_i && (cnt_i != '0);
            aligned_o = 1'b1;
            cnt_n     = CNT_W'(1);
            sh0_o     = sh0_shift;
            sh1_o     = sh1_shift;
        end else if (aligned_i) begin
            cnt_n = cnt_i + CNT_W'(1);
            sh0_o = sh0_shift;
            sh1_o = sh1_shift;
        end
        if (aligned_o && (cnt_n == bpl_i)) begin
            done_o = 1'b1;
            cnt_o  = '0;
        end else begin
            cnt_o = cnt_n;
        end
        prev_f_o  = f_i;
        prev_ok_o = 1'b1;
    end
endmodule

// File: rtl/adcdes_word_pack.sv
module adcdes_word_pack
    import adcdes_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int SH0_W    = SAMPLE_W + 2,
    parameter int SH1_W    = SH0_W / 2
) (
    input  logic [SH0_W-1:0]    sh0_i,
    input  logic [SH1_W-1:0]    sh1_i,
    input  logic                two_lane_i,
    input  logic [1:0]          ser_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    logic [SH0_W-1:0] inter;
    logic [SH0_W-1:0] word;
    ser_mode_e        ser;

    always_comb begin
        // lane 1 holds odd indices, lane 0 even indices
        for (int i = 0; i < SH1_W; i++) begin
            inter[2*i+1] = sh1_i[i];
            inter[2*i]   = sh0_i[i];
        end
        word = two_lane_i ? inter : sh0_i;
        ser  = ser_mode_e'(ser_i);
        case (ser)
            SER_NATIVE: sample_o = word[SAMPLE_W-1:0];
            SER_TRUNC:  sample_o = {word[SAMPLE_W-3:0], 2'b00};
            default:    sample_o = word[SAMPLE_W+1:2];
        endcase
    end
endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser
    import adcdes_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                two_lane_i,
    input  logic [1:0]          ser_mode_i,
    input  logic [1:0]          rise_data_i,
    input  logic [1:0]          fall_data_i,
    input  logic                frame_rise_i,
    input  logic                frame_fall_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_valid_o,
    output logic                frame_err_o
);
    localparam int SH0_W    = SAMPLE_W + 2;
    localparam int SH1_W    = SH0_W / 2;
    localparam int CNT_W    = $clog2(SH0_W + 1);
    localparam int NUM_HALF = HALVES_PER_CLK;

    typedef struct packed {
        logic                prev_f;
        logic                prev_ok;
        logic                aligned;
        logic [CNT_W-1:0]    cnt;
        logic [SH0_W-1:0]    sh0;
        logic [SH1_W-1:0]    sh1;
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
        logic                err;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] bpl;
    logic             split;

    adcdes_cfg_decode #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_cfg (
        .two_lane_i (two_lane_i),
        .ser_i      (ser_mode_i),
        .bpl_o      (bpl),
        .split_o    (split)
    );

    // index 0 is the earlier (rising-edge) half of the cycle
    logic [NUM_HALF-1:0] l0_bits, l1_bits, f_bits;
    assign l0_bits = {fall_data_i[0], rise_data_i[0]};
    assign l1_bits = {fall_data_i[1], rise_data_i[1]};
    assign f_bits  = {frame_fall_i, frame_rise_i};

    logic             pf_c  [NUM_HALF+1];
    logic             pok_c [NUM_HALF+1];
    logic             al_c  [NUM_HALF+1];
    logic [CNT_W-1:0] cnt_c [NUM_HALF+1];
    logic [SH0_W-1:0] sh0_c [NUM_HALF+1];
    logic [SH1_W-1:0] sh1_c [NUM_HALF+1];

    logic [NUM_HALF-1:0] done_h, err_h;
    logic [SAMPLE_W-1:0] pk_s [NUM_HALF];

    assign pf_c[0]  = st_q.prev_f;
    assign pok_c[0] = st_q.prev_ok;
    assign al_c[0]  = st_q.aligned;
    assign cnt_c[0] = st_q.cnt;
    assign sh0_c[0] = st_q.sh0;
    assign sh1_c[0] = st_q.sh1;

    for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
        adcdes_bit_step #(.SH0_W(SH0_W), .SH1_W(SH1_W), .CNT_W(CNT_W)) u_step (
            .prev_f_i  (pf_c[g]),
            .prev_ok_i (pok_c[g]),
            .aligned_i (al_c[g]),
            .cnt_i     (cnt_c[g]),
            .sh0_i     (sh0_c[g]),
            .sh1_i     (sh1_c[g]),
            .b0_i      (l0_bits[g]),
            .b1_i      (l1_bits[g]),
            .f_i       (f_bits[g]),
            .bpl_i     (bpl),
            .split_i   (split),
            .prev_f_o  (pf_c[g+1]),
            .prev_ok_o (pok_c[g+1]),
            .aligned_o (al_c[g+1]),
            .cnt_o     (cnt_c[g+1]),
            .sh0_o     (sh0_c[g+1]),
            .sh1_o     (sh1_c[g+1]),
            .done_o    (done_h[g]),
            .err_o     (err_h[g])
        );

        adcdes_word_pack #(.SAMPLE_W(SAMPLE_W), .SH0_W(SH0_W), .SH1_W(SH1_W)) u_pack (
            .sh0_i      (sh0_c[g+1]),
            .sh1_i      (sh1_c[g+1]),
            .two_lane_i (two_lane_i),
            .ser_i      (ser_mode_i),
            .sample_o   (pk_s[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.prev_f  = pf_c[NUM_HALF];
        st_d.prev_ok = pok_c[NUM_HALF];
        st_d.aligned = al_c[NUM_HALF];
        st_d.cnt     = cnt_c[NUM_HALF];
        st_d.sh0     = sh0_c[NUM_HALF];
        st_d.sh1     = sh1_c[NUM_HALF];
        st_d.valid   = |done_h;
        for (int h = 0; h < NUM_HALF; h++) begin
            if (done_h[h]) begin
                st_d.sample = pk_s[h];
            end
        end
        st_d.err = st_q.err | (|err_h);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o       = st_q.sample;
    assign sample_valid_o = st_q.valid;
    assign frame_err_o    = st_q.err;
endmodule

// File: rtl/adcdes_frame_chk.sv
module adcdes_frame_chk #(
    parameter int SAMPLE_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          ser_mode_i,
    input logic                frame_rise_i,
    input logic                frame_fall_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                sample_valid_o,
    input logic                frame_err_o
);
    logic seen_q, pf_q, pok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            pf_q   <= 1'b0;
            pok_q  <= 1'b0;
        end else begin
            pok_q <= 1'b1;
            pf_q  <= frame_fall_i;
            if ((pok_q && (pf_q != frame_rise_i)) || (frame_rise_i != frame_fall_i)) begin
                seen_q <= 1'b1;
            end
        end
    end

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o);

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);

    p_hold_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_o |-> $stable(sample_o));

    p_trunc_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_o && ser_mode_i == 2'b10) |-> (sample_o[1:0] == 2'b00));

    p_no_strobe_unaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !sample_valid_o);
endmodule

bind adc_frame_deser adcdes_frame_chk #(.SAMPLE_W(SAMPLE_W)) u_frame_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ser_mode_i     (ser_mode_i),
    .frame_rise_i   (frame_rise_i),
    .frame_fall_i   (frame_fall_i),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o),
    .frame_err_o    (frame_err_o)
);

// File: tb/adc_frame_deser_test.sv
module adc_frame_deser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        two_lane_i = 1'b0;
    logic [1:0]  ser_mode_i = 2'b00;
    logic [1:0]  rise_data_i = 2'b00;
    logic [1:0]  fall_data_i = 2'b00;
    logic        frame_rise_i = 1'b0;
    logic        frame_fall_i = 1'b0;
    logic [13:0] sample_o;
    logic        sample_valid_o;
    logic        frame_err_o;

    always #5 clk = ~clk;

    adc_frame_deser #(.SAMPLE_W(14)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .two_lane_i     (two_lane_i),
        .ser_mode_i     (ser_mode_i),
        .rise_data_i    (rise_data_i),
        .fall_data_i    (fall_data_i),
        .frame_rise_i   (frame_rise_i),
        .frame_fall_i   (frame_fall_i),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o),
        .frame_err_o    (frame_err_o)
    );

    localparam int MAXH = 512;
    localparam int MAXC = 256;

    int checks = 0;
    int fails  = 0;

    bit          hl0 [MAXH];
    bit          hl1 [MAXH];
    bit          hf  [MAXH];
    bit          ev  [MAXC];
    bit          ee  [MAXC];
    logic [13:0] es  [MAXC];
    int          ncyc;
    int          seg_len [8];
    bit          seg_edge [8];
    int          nseg;
    int          lead_x;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int bpl_of(input int lm, input int sm);
        int w;
        w = (sm == 1) ? 14 : (sm == 2) ? 12 : 16;
        return lm ? w / 2 : w;
    endfunction

    // Build the half-bit stream and the per-cycle expectations.
    task automatic build(input int lm, input int sm);
        int w, bpl, h, lead, widx, last, err_from;
        bit split, aligned, partial, lvl;
        w     = (sm == 1) ? 14 : (sm == 2) ? 12 : 16;
        bpl   = lm ? w / 2 : w;
        split = (lm == 1) && (sm == 1);
        for (int i = 0; i < MAXH; i++) begin
            hl0[i] = 0; hl1[i] = 0; hf[i] = 0;
        end
        for (int i = 0; i < MAXC; i++) begin
            ev[i] = 0; ee[i] = 0; es[i] = '0;
        end
        lead = 3 + 2 * lm + sm + lead_x;
        h = 0;
        for (int i = 0; i < lead; i++) begin
            hl0[h] = i[0]; hl1[h] = i[1]; hf[h] = 0; h++;
        end
        aligned = 0; partial = 0; lvl = 0; widx = 0; last = 0; err_from = -1;
        for (int k = 0; k < nseg; k++) begin
            int len, sw, s, start;
            bit eh;
            len   = seg_len[k];
            start = h;
            eh    = split ? 1'b1 : seg_edge[k];
            if (split) lvl = !lvl;
            if (eh && aligned && partial && err_from < 0) err_from = start / 2;
            if (eh) aligned = 1;
            s  = (widx * 4951 + sm * 677 + lm * 3001 + 241) % 16384;
            sw = (w == 16) ? (s * 4 + 3) : (w == 14) ? s : (s >> 2);
            for (int j = 0; j < len; j++) begin
                if (lm == 1) begin
                    hl1[h] = sw[w-1-2*j];
                    hl0[h] = sw[w-2-2*j];
                end else begin
                    hl0[h] = sw[w-1-j];
                    hl1[h] = j[0];
                end
                hf[h] = split ? lvl : (eh && (j < (len + 1) / 2));
                h++;
            end
            partial = (len != bpl);
            if (!partial && aligned) begin
                int c;
                c = (h - 1) / 2;
                ev[c] = 1;
                es[c] = (w == 12) ? 14'(s & 16'h3FFC) : 14'(s);
                last = c;
                widx++;
            end
        end
        ncyc = last + 3;
        for (; h < 2 * ncyc; h++) begin
            hl0[h] = 0; hl1[h] = 0; hf[h] = split ? lvl : 1'b0;
        end
        for (int c = 0; c < ncyc; c++) begin
            ee[c] = (err_from >= 0) && (c >= err_from);
        end
    endtask

    task automatic run(input int lm, input int sm, input string name);
        string stag;
        build(lm, sm);
        stag = (lm == 1) ? ((sm == 1) ? "R3 R6" : "R3") : "R2";
        if (sm == 0) stag = {stag, " R4"};
        if (sm == 2) stag = {stag, " R5"};
        @(negedge clk);
        rst_n        = 1'b0;
        two_lane_i   = lm[0];
        ser_mode_i   = sm[1:0];
        rise_data_i  = 2'b00;
        fall_data_i  = 2'b00;
        frame_rise_i = 1'b0;
        frame_fall_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(sample_valid_o == 1'b0, {name, " R10 valid in reset"}, int'(sample_valid_o), 0);
        chk(frame_err_o == 1'b0, {name, " R10 err in reset"}, int'(frame_err_o), 0);
        chk(sample_o == 14'd0, {name, " R10 sample in reset"}, int'(sample_o), 0);
        rst_n = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            rise_data_i  = {hl1[2*c], hl0[2*c]};
            fall_data_i  = {hl1[2*c+1], hl0[2*c+1]};
            frame_rise_i = hf[2*c];
            frame_fall_i = hf[2*c+1];
            @(negedge clk);
            chk(sample_valid_o == ev[c], $sformatf("%s R7 R8 R11 valid cycle %0d", name, c),
                int'(sample_valid_o), int'(ev[c]));
            if (ev[c]) begin
                chk(sample_o == es[c], $sformatf("%s R1 %s sample cycle %0d", name, stag, c),
                    int'(sample_o), int'(es[c]));
            end
            chk(frame_err_o == ee[c], $sformatf("%s R9 frame_err cycle %0d", name, c),
                int'(frame_err_o), int'(ee[c]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // full sweep over lane count and serialization width
        lead_x = 0;
        for (int lm = 0; lm < 2; lm++) begin
            for (int sm = 0; sm < 3; sm++) begin
                nseg = 4;
                for (int k = 0; k < 4; k++) begin
                    seg_len[k] = bpl_of(lm, sm); seg_edge[k] = 1;
                end
                run(lm, sm, $sformatf("sweep lm%0d sm%0d", lm, sm));
            end
        end
        // R11: free running after a single marker edge
        nseg = 3;
        for (int k = 0; k < 3; k++) begin
            seg_len[k] = 14; seg_edge[k] = (k == 0);
        end
        run(0, 1, "r11_one_lane");
        nseg = 4;
        for (int k = 0; k < 4; k++) begin
            seg_len[k] = 8; seg_edge[k] = (k == 0);
        end
        run(1, 0, "r11_two_lane");
        // R9: marker edge in the middle of a word
        nseg = 4;
        seg_len[0] = 16; seg_len[1] = 5; seg_len[2] = 16; seg_len[3] = 16;
        for (int k = 0; k < 4; k++) seg_edge[k] = 1;
        run(0, 0, "r9_one_lane16");
        seg_len[0] = 6; seg_len[1] = 3; seg_len[2] = 6; seg_len[3] = 6;
        run(1, 2, "r9_two_lane12");
        seg_len[0] = 7; seg_len[1] = 4; seg_len[2] = 7; seg_len[3] = 7;
        run(1, 1, "r9_split");
        // R8: long idle data before the first marker edge
        lead_x = 41;
        nseg = 3;
        for (int k = 0; k < 3; k++) begin
            seg_len[k] = 7; seg_edge[k] = 1;
        end
        run(1, 1, "r8_long_idle");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule